// File: doc/BRIEF.md
# Run-Time Programmable Address Region Decoder

This block sorts every 32-bit byte address issued by a small processor core into one of three regions: a boot ROM whose place is fixed by parameters, a RAM window, and a small I/O window. It returns the region that was hit and the address relative to that region's base. It raises a write strobe toward RAM or I/O only when a store lands in one of them. Stores into ROM and accesses that hit nothing are reported as faults, and no strobe is raised.

The RAM window and the I/O window start out unmapped. The core places them with configuration commands that carry two operand values, A and B. One command sets the RAM base and size. One sets the stack start and hands that value to the core's stack pointer. One places the fixed-size I/O window. Any other command code raises an error pulse and changes nothing. The decode is combinational, so an access is classified in the cycle it is presented. A configuration command takes effect from the following cycle.

Top module: `addr_region_dec`

## Requirements
- R1: After reset the ROM occupies byte addresses ROM_BASE up to ROM_BASE+ROM_BYTES-1 (default 0 to 255). RAM and I/O are unmapped and stack_base is 0. Address 256 therefore decodes as unmapped.
- R2: A command with cfg_sel = 0 sets the RAM base from cfg_a and the RAM size in bytes from cfg_b. The new window is used for accesses from the next cycle on. An access in the same cycle sees the old window.
- R3: A command with cfg_sel = 1 pulses sp_load in the same cycle, with sp_value equal to cfg_a. From the next cycle stack_base holds cfg_a.
- R4: A command with cfg_sel = 2 places and enables the I/O window at base cfg_a. The window is IO_BYTES (default 12) bytes long, from the next cycle.
- R5: A command with cfg_sel from 3 to 15 pulses cfg_err in its cycle and changes no window and no stack start.
- R6: When windows overlap, ROM wins over RAM and RAM wins over I/O. The region code is 01 for ROM, 10 for RAM, 11 for I/O and 00 for none.
- R7: On a hit, offset equals the address minus the winning region's base. On a miss, offset is 0.
- R8: A valid store that hits ROM gives fault_valid = 1 and fault_code = 01 (write protect), with ram_we and io_we low.
- R9: A valid access that hits no region gives fault_valid = 1 and fault_code = 10 (unmapped), with no strobe.
- R10: A valid store hitting RAM raises only ram_we, and one hitting I/O raises only io_we. Loads and cycles with acc_valid low raise no strobe and no fault, and fault_code is then 00.
- R11: Range checks use base <= address < base+size computed with one extra bit. A window that ends exactly at 2^32 includes address 0xFFFFFFFF, and a window running past 2^32 does not wrap to low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration command present |
| cfg_sel | input | 4 | Command code: 0 RAM, 1 stack, 2 I/O, other invalid |
| cfg_a | input | 32 | Operand A (base or stack start) |
| cfg_b | input | 32 | Operand B (RAM size in bytes) |
| sp_load | output | 1 | Stack pointer load pulse |
| sp_value | output | 32 | Value to load into the stack pointer |
| stack_base | output | 32 | Programmed stack start |
| cfg_err | output | 1 | Invalid command pulse |
| acc_valid | input | 1 | Access present |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Byte address |
| region | output | 2 | Region hit: 00 none, 01 ROM, 10 RAM, 11 I/O |
| offset | output | 32 | Address relative to region base |
| ram_we | output | 1 | Store strobe to RAM |
| io_we | output | 1 | Store strobe to I/O window |
| fault_valid | output | 1 | Fault pulse |
| fault_code | output | 2 | 01 write protect, 10 unmapped |

## Verification
Some properties are checked on every cycle. Stores into the ROM range never produce a strobe and always carry the write-protect code. At most one of the two strobes and the fault pulse is high at a time. An I/O hit never yields an offset beyond the window. A rejected command leaves every window register unchanged, and a stack command lands in stack_base on the next edge. Only the bench scenarios can show the rest. These are the decoding of specific addresses against windows placed at run time, the one-cycle delay before a new window applies, the priority among overlapping windows, and the top-of-space cases, where a window ending at 2^32 must match while one running past it must not reach low addresses.

// File: rtl/addr_region_dec.sv
module addr_region_dec #(
  parameter int AW        = 32,
  parameter int SELW      = 4,
  parameter int ROM_BASE  = 0,
  parameter int ROM_BYTES = 256,
  parameter int IO_BYTES  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [AW-1:0]   cfg_a,
  input  logic [AW-1:0]   cfg_b,
  output logic            sp_load,
  output logic [AW-1:0]   sp_value,
  output logic [AW-1:0]   stack_base,
  output logic            cfg_err,
  input  logic            acc_valid,
  input  logic            acc_store,
  input  logic [AW-1:0]   acc_addr,
  output logic [1:0]      region,
  output logic [AW-1:0]   offset,
  output logic            ram_we,
  output logic            io_we,
  output logic            fault_valid,
  output logic [1:0]      fault_code
);

  localparam logic [1:0] RG_NONE = 2'b00, RG_ROM = 2'b01, RG_RAM = 2'b10, RG_IO = 2'b11;
  localparam logic [1:0] FC_NONE = 2'b00, FC_WP = 2'b01, FC_UNMAP = 2'b10;
  localparam logic [AW:0]   ROM_LO  = (AW+1)'(ROM_BASE);
  localparam logic [AW:0]   ROM_END = ROM_LO + (AW+1)'(ROM_BYTES);
  localparam logic [AW-1:0] ROM_B   = AW'(ROM_BASE);

  logic [AW-1:0] ram_base_q, ram_size_q, io_base_q, stack_q;
  logic          io_on_q;

  wire sel_ram   = cfg_valid && (cfg_sel == SELW'(0));
  wire sel_stack = cfg_valid && (cfg_sel == SELW'(1));
  wire sel_io    = cfg_valid && (cfg_sel == SELW'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_base_q <= '0;
      ram_size_q <= '0;
      io_base_q  <= '0;
      io_on_q    <= 1'b0;
      stack_q    <= '0;
    end else begin
      if (sel_ram) begin
        ram_base_q <= cfg_a;
        ram_size_q <= cfg_b;
      end
      if (sel_stack) stack_q <= cfg_a;
      if (sel_io) begin
        io_base_q <= cfg_a;
        io_on_q   <= 1'b1;
      end
    end
  end

  assign sp_load    = sel_stack;
  assign sp_value   = cfg_a;
  assign stack_base = stack_q;
  assign cfg_err    = cfg_valid && (cfg_sel > SELW'(2));

  wire [AW:0] addr_x  = {1'b0, acc_addr};
  wire [AW:0] ram_lo  = {1'b0, ram_base_q};
  wire [AW:0] ram_end = ram_lo + {1'b0, ram_size_q};
  wire [AW:0] io_lo   = {1'b0, io_base_q};
  wire [AW:0] io_end  = io_lo + (AW+1)'(IO_BYTES);

  wire in_rom = (addr_x >= ROM_LO) && (addr_x < ROM_END);
  wire in_ram = (addr_x >= ram_lo) && (addr_x < ram_end);
  wire in_io  = io_on_q && (addr_x >= io_lo) && (addr_x < io_end);

  always_comb begin
    region = RG_NONE;
    offset = '0;
    if (in_rom) begin
      region = RG_ROM;
      offset = acc_addr - ROM_B;
    end else if (in_ram) begin
      region = RG_RAM;
      offset = acc_addr - ram_base_q;
    end else if (in_io) begin
      region = RG_IO;
      offset = acc_addr - io_base_q;
    end
  end

  always_comb begin
    fault_code = FC_NONE;
    if (acc_valid) begin
      if (region == RG_NONE)                  fault_code = FC_UNMAP;
      else if (region == RG_ROM && acc_store) fault_code = FC_WP;
    end
  end

  assign fault_valid = fault_code != FC_NONE;
  assign ram_we      = acc_valid && acc_store && (region == RG_RAM);
  assign io_we       = acc_valid && acc_store && (region == RG_IO);

  // R8
  rom_store_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_store && addr_x >= ROM_LO && addr_x < ROM_END)
      |-> (fault_valid && fault_code == FC_WP && !ram_we && !io_we));

  // R10
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, io_we, fault_valid}));

  // R7
  io_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_IO) |-> (offset < AW'(IO_BYTES)));

  // R5
  bad_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> ($stable(ram_base_q) && $stable(ram_size_q) && $stable(io_base_q)
                 && $stable(io_on_q) && $stable(stack_q)));

  // R3
  stack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> (stack_base == $past(cfg_a)));

endmodule

// File: tb/addr_region_dec_tb.sv
module addr_region_dec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_a = '0, cfg_b = '0;
  logic        sp_load, cfg_err;
  logic [31:0] sp_value, stack_base;
  logic        acc_valid = 1'b0, acc_store = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  region, fault_code;
  logic [31:0] offset;
  logic        ram_we, io_we, fault_valid;

  always #10 clk = ~clk;

  addr_region_dec u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .sp_load(sp_load), .sp_value(sp_value),
    .stack_base(stack_base), .cfg_err(cfg_err), .acc_valid(acc_valid),
    .acc_store(acc_store), .acc_addr(acc_addr), .region(region), .offset(offset),
    .ram_we(ram_we), .io_we(io_we), .fault_valid(fault_valid), .fault_code(fault_code));

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_ram_base = 0, m_ram_size = 0, m_io_base = 0, m_stack = 0;
  logic        m_io_on = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic predict(input logic [31:0] ad, input logic av, input logic st,
                         output logic [1:0] rg, output logic [31:0] off,
                         output logic rw, output logic iw, output logic [1:0] fc);
    logic [32:0] x;
    x = {1'b0, ad};
    rg = 2'b00; off = 0;
    if (x < 33'd256) begin rg = 2'b01; off = ad; end
    else if (x >= {1'b0, m_ram_base} && x < {1'b0, m_ram_base} + {1'b0, m_ram_size}) begin
      rg = 2'b10; off = ad - m_ram_base; end
    else if (m_io_on && x >= {1'b0, m_io_base} && x < {1'b0, m_io_base} + 33'd12) begin
      rg = 2'b11; off = ad - m_io_base; end
    rw = av && st && rg == 2'b10;
    iw = av && st && rg == 2'b11;
    fc = 2'b00;
    if (av && rg == 2'b00) fc = 2'b10;
    else if (av && st && rg == 2'b01) fc = 2'b01;
  endtask

  task automatic step(input string tag, input logic cv, input logic [3:0] sel,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic av, input logic st, input logic [31:0] ad);
    logic [1:0] rg, fc;
    logic [31:0] off;
    logic rw, iw;
    @(negedge clk);
    cfg_valid = cv; cfg_sel = sel; cfg_a = a; cfg_b = b;
    acc_valid = av; acc_store = st; acc_addr = ad;
    #5;
    predict(ad, av, st, rg, off, rw, iw, fc);
    chk(tag, "region", 32'(region), 32'(rg));
    chk(tag, "offset", offset, off);
    chk(tag, "ram_we", 32'(ram_we), 32'(rw));
    chk(tag, "io_we", 32'(io_we), 32'(iw));
    chk(tag, "fault_code", 32'(fault_code), 32'(fc));
    chk(tag, "fault_valid", 32'(fault_valid), 32'(fc != 2'b00));
    chk(tag, "cfg_err", 32'(cfg_err), 32'(cv && sel > 4'd2));
    chk(tag, "sp_load", 32'(sp_load), 32'(cv && sel == 4'd1));
    if (cv && sel == 4'd1) chk(tag, "sp_value", sp_value, a);
    chk(tag, "stack_base", stack_base, m_stack);
    if (cv) begin
      if (sel == 4'd0) begin m_ram_base = a; m_ram_size = b; end
      if (sel == 4'd1) m_stack = a;
      if (sel == 4'd2) begin m_io_base = a; m_io_on = 1'b1; end
    end
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a, ad;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    step("R1", 0, 0, 0, 0, 1, 0, 32'h0);
    step("R1", 0, 0, 0, 0, 1, 0, 32'hFF);
    step("R1", 0, 0, 0, 0, 1, 0, 32'h100);
    step("R9", 0, 0, 0, 0, 1, 1, 32'h2000);
    // R2 RAM placement with one-cycle latency
    step("R2", 1, 0, 32'h1000, 32'h100, 1, 0, 32'h1000);
    step("R2", 0, 0, 0, 0, 1, 0, 32'h1000);
    step("R10", 0, 0, 0, 0, 1, 1, 32'h10FF);
    step("R9", 0, 0, 0, 0, 1, 1, 32'h1100);
    step("R10", 0, 0, 0, 0, 0, 1, 32'h1004);
    // R3 stack start
    step("R3", 1, 1, 32'h1080, 0, 0, 0, 32'h0);
    step("R3", 0, 0, 0, 0, 0, 0, 32'h0);
    // R4 I/O window
    step("R4", 1, 2, 32'h2000, 0, 1, 0, 32'h2000);
    step("R4", 0, 0, 0, 0, 1, 0, 32'h2000);
    step("R4", 0, 0, 0, 0, 1, 1, 32'h200B);
    step("R4", 0, 0, 0, 0, 1, 1, 32'h200C);
    // R5 invalid commands
    step("R5", 1, 3, 32'h5000, 32'h10, 0, 0, 0);
    step("R5", 1, 15, 32'h6000, 32'h10, 1, 0, 32'h1000);
    step("R5", 0, 0, 0, 0, 1, 0, 32'h5000);
    step("R5", 0, 0, 0, 0, 1, 0, 32'h2004);
    // R8 ROM write protection
    step("R8", 0, 0, 0, 0, 1, 1, 32'h10);
    step("R8", 0, 0, 0, 0, 1, 1, 32'hFF);
    // R6 priority with overlapping windows
    step("R6", 1, 0, 32'h80, 32'h1000, 0, 0, 0);
    step("R6", 1, 2, 32'h1000, 0, 1, 0, 32'h80);
    step("R6", 0, 0, 0, 0, 1, 0, 32'h100);
    step("R6", 0, 0, 0, 0, 1, 1, 32'h1004);
    step("R7", 0, 0, 0, 0, 1, 0, 32'h1080);
    // R11 top of address space
    step("R11", 1, 0, 32'hFFFFFF00, 32'h100, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 1, 1, 32'hFFFFFFFF);
    step("R11", 0, 0, 0, 0, 1, 0, 32'hFFFFFF00);
    step("R11", 1, 0, 32'hFFFFFF00, 32'h400, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 1, 0, 32'h200);
    step("R11", 0, 0, 0, 0, 1, 0, 32'hFFFFFFFF);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic cv;
      logic [3:0] sel;
      cv  = ($urandom % 8) == 0;
      sel = 4'($urandom % 5);
      a   = ($urandom % 4 == 0) ? $urandom : (32'h100 + ($urandom % 32'h4000));
      case ($urandom % 5)
        0: ad = 32'hF0 + ($urandom % 32);
        1: ad = m_ram_base + ($urandom % 16) - 4 + (($urandom % 2) ? m_ram_size : 0);
        2: ad = m_io_base + ($urandom % 20) - 4;
        3: ad = 32'hFFFFFFF0 + ($urandom % 16);
        default: ad = $urandom;
      endcase
      step(i[0] ? "R7" : "R10", cv, sel, a, $urandom % 32'h2000,
           1'($urandom), 1'($urandom), ad);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule